// File: doc/BRIEF.md
# TCP Transmit Byte Packetizer

This block takes a byte stream from a user writer and groups it into TCP payload segments. Each accepted byte goes into a circular byte buffer. The block tracks how many bytes are pending in the segment that is still open. It closes that segment for one of three reasons: the pending count reaches the payload limit, the writer has gone quiet for a programmable number of clock ticks, or a force-send strobe arrives. Each closed segment is pushed into a small in-order queue as a descriptor. The descriptor carries the buffer offset of the segment's first byte and the segment's length.

Downstream, the segment builder pops descriptors with a valid/ready handshake and fetches the payload through a registered read port. It returns buffer space with a release strobe once it no longer needs those bytes. Clear-to-send drops early enough that one further byte can still be taken safely. This lets a writer react to clear-to-send with one cycle of delay.

Top module: `tcp_tx_packetizer`

## Requirements
- R1: After reset, cts_o is high, desc_valid_o is low, and the first segment starts at buffer offset 0.
- R2: When the pending count reaches MTU bytes, the segment closes on the same clock edge that accepts the last byte. desc_len_o never exceeds MTU and is never zero.
- R3: If bytes are pending and no byte is accepted for WAIT_TICKS cycles, the segment closes. Its descriptor becomes visible exactly WAIT_TICKS clock edges after the edge that accepted the last byte.
- R4: Every accepted byte restarts the idle count. Bytes spaced WAIT_TICKS-1 edges apart therefore stay in one segment.
- R5: snd_i high with bytes pending closes the segment at that edge. A byte accepted in the same cycle is included in that segment.
- R6: snd_i with no pending byte and no byte in the same cycle creates no descriptor.
- R7: cts_o is low whenever two or fewer buffer bytes are free.
- R8: One byte presented in the first cycle that cts_o is low is still accepted and stored.
- R9: cts_o is low while the descriptor queue is full.
- R10: Descriptors leave in closing order. Each start offset is the previous start plus the previous length, modulo the buffer size. A descriptor holds steady while desc_ready_i is low.
- R11: rd_data_o shows the buffer byte at rd_addr_i one clock edge after the address is applied.
- R12: rel_valid_i returns rel_len_i bytes of buffer space, so cts_o can rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 8 | Write byte |
| vin_i | input | 1 | Write byte valid |
| cts_o | output | 1 | Clear to send |
| snd_i | input | 1 | Force-send strobe |
| desc_valid_o | output | 1 | Descriptor available |
| desc_ready_i | input | 1 | Descriptor taken |
| desc_start_o | output | ADDR_W | Buffer offset of first segment byte |
| desc_len_o | output | clog2(MTU+1) | Segment length in bytes |
| rd_addr_i | input | ADDR_W | Payload read address |
| rd_data_o | output | 8 | Payload byte, one cycle after address |
| rel_valid_i | input | 1 | Release strobe |
| rel_len_i | input | ADDR_W+1 | Number of bytes released |

## Verification
The bench times the idle close to the exact edge: a counter that is off by one moves the descriptor one cycle early or late. It spaces bytes just short of the idle window; a timer that did not restart would split them into two segments. It sends a force strobe with nothing pending, where a careless close condition emits a zero-length descriptor. It also sends a force strobe together with a byte, where a design that ignores the byte leaves it orphaned. It fills the buffer to the clear-to-send limit, checks the one extra byte landed by reading it back, and then fills the descriptor queue. A design with a wrong threshold or a lost byte shows a wrong count, wrong data or wrong offsets on the segments that follow.

// File: rtl/tcp_pktz_pkg.sv
package tcp_pktz_pkg;
  typedef enum logic [1:0] {
    CLOSE_NONE,
    CLOSE_SIZE,
    CLOSE_FORCE,
    CLOSE_IDLE
  } close_cause_e;
endpackage

// File: rtl/tcp_pktz_buf.sv
module tcp_pktz_buf #(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [7:0]        din_i,
  input  logic              rel_valid_i,
  input  logic [CNT_W-1:0]  rel_len_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic [CNT_W-1:0]  used_o
);
  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] wr_q;
  logic [CNT_W-1:0]  used_q;
  logic [CNT_W-1:0]  rel_amt;

  assign rel_amt = rel_valid_i ? rel_len_i : '0;

  always_ff @(posedge clk_i) begin
    if (acc_i) mem[wr_q] <= din_i;
    rd_data_o <= mem[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      used_q <= '0;
    end else begin
      if (acc_i) wr_q <= wr_q + 1'b1;
      used_q <= used_q + CNT_W'(acc_i) - rel_amt;
    end
  end

  assign wr_ptr_o = wr_q;
  assign used_o   = used_q;
endmodule

// File: rtl/tcp_pktz_seg.sv
module tcp_pktz_seg
  import tcp_pktz_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int MTU        = 1400,
  parameter int WAIT_TICKS = 125,
  localparam int LEN_W  = $clog2(MTU + 1),
  localparam int IDLE_W = $clog2(WAIT_TICKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              snd_i,
  input  logic              dq_full_i,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_start_o,
  output logic [LEN_W-1:0]  push_len_o,
  output logic [LEN_W-1:0]  pend_len_o
);
  localparam logic [LEN_W-1:0]  MTU_C    = LEN_W'(MTU);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(WAIT_TICKS - 1);

  logic [LEN_W-1:0]  pend_q, pend_nx;
  logic [ADDR_W-1:0] start_q;
  logic [IDLE_W-1:0] idle_q;
  close_cause_e      cause;

  assign pend_nx = pend_q + LEN_W'(acc_i);

  // size beats force beats idle; all three close the same bytes
  always_comb begin
    cause = CLOSE_NONE;
    if (pend_nx == MTU_C)                                 cause = CLOSE_SIZE;
    else if (snd_i && pend_nx != '0)                      cause = CLOSE_FORCE;
    else if (!acc_i && pend_q != '0 && idle_q == IDLE_LIM) cause = CLOSE_IDLE;
  end

  assign push_o       = (cause != CLOSE_NONE) && !dq_full_i;
  assign push_start_o = start_q;
  assign push_len_o   = pend_nx;
  assign pend_len_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      start_q <= '0;
      idle_q  <= '0;
    end else if (push_o) begin
      pend_q  <= '0;
      start_q <= start_q + ADDR_W'(pend_nx);
      idle_q  <= '0;
    end else begin
      pend_q <= pend_nx;
      if (acc_i)                                  idle_q <= '0;
      else if (pend_q != '0 && idle_q != IDLE_LIM) idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/tcp_pktz_dq.sv
module tcp_pktz_dq #(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 11,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic              full_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] st_mem [DEPTH];
  logic [LEN_W-1:0]  ln_mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  assign valid_o = cnt_q != '0;
  assign full_o  = cnt_q == FULLC;
  assign start_o = st_mem[rd_q];
  assign len_o   = ln_mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      st_mem[wr_q] <= start_i;
      ln_mem[wr_q] <= len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end
endmodule

// File: rtl/tcp_tx_packetizer.sv
module tcp_tx_packetizer #(
  parameter int ADDR_W     = 11,
  parameter int MTU        = 1400,
  parameter int WAIT_TICKS = 125,
  parameter int DQ_DEPTH   = 4,
  localparam int LEN_W = $clog2(MTU + 1),
  localparam int CNT_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        din_i,
  input  logic              vin_i,
  output logic              cts_o,
  input  logic              snd_i,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [ADDR_W-1:0] desc_start_o,
  output logic [LEN_W-1:0]  desc_len_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              rel_valid_i,
  input  logic [CNT_W-1:0]  rel_len_i
);
  localparam logic [CNT_W-1:0] CTS_LIM = CNT_W'(DEPTH - 2);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);
  localparam logic [LEN_W-1:0] MTU_C   = LEN_W'(MTU);

  logic              acc;
  logic [ADDR_W-1:0] wr_ptr;
  logic [CNT_W-1:0]  used_cnt;
  logic              seg_push;
  logic [ADDR_W-1:0] seg_start;
  logic [LEN_W-1:0]  seg_len;
  logic [LEN_W-1:0]  pend_len;
  logic              dq_full;

  // guards only; the writer contract keeps both conditions from occurring
  assign acc   = vin_i && (used_cnt != FULL_C) && (pend_len != MTU_C);
  assign cts_o = (used_cnt < CTS_LIM) && !dq_full;

  tcp_pktz_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .din_i(din_i),
    .rel_valid_i(rel_valid_i), .rel_len_i(rel_len_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wr_ptr_o(wr_ptr), .used_o(used_cnt)
  );

  tcp_pktz_seg #(.ADDR_W(ADDR_W), .MTU(MTU), .WAIT_TICKS(WAIT_TICKS)) u_seg (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .snd_i(snd_i),
    .dq_full_i(dq_full), .push_o(seg_push), .push_start_o(seg_start),
    .push_len_o(seg_len), .pend_len_o(pend_len)
  );

  tcp_pktz_dq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DQ_DEPTH)) u_dq (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(seg_push), .start_i(seg_start),
    .len_i(seg_len), .pop_i(desc_valid_o && desc_ready_i),
    .valid_o(desc_valid_o), .full_o(dq_full),
    .start_o(desc_start_o), .len_o(desc_len_o)
  );

  logic unused_ok;
  assign unused_ok = ^wr_ptr;
endmodule

// File: rtl/tcp_pktz_chk.sv
module tcp_pktz_chk #(
  parameter int ADDR_W = 11,
  parameter int MTU    = 1400,
  parameter int LEN_W  = 11,
  localparam int CNT_W = ADDR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cts_i,
  input logic              desc_valid_i,
  input logic              desc_ready_i,
  input logic [ADDR_W-1:0] desc_start_i,
  input logic [LEN_W-1:0]  desc_len_i,
  input logic              dq_full_i,
  input logic              push_i,
  input logic [LEN_W-1:0]  pend_len_i,
  input logic [CNT_W-1:0]  used_i
);
  localparam logic [LEN_W-1:0] MTU_C   = LEN_W'(MTU);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);

  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i |-> (desc_len_i != '0) && (desc_len_i <= MTU_C)); // R2
  AST_PEND_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_len_i <= MTU_C); // R2
  AST_DESC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_i && !desc_ready_i |=> desc_valid_i && $stable(desc_start_i) && $stable(desc_len_i)); // R10
  AST_PUSH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !dq_full_i); // R10
  AST_CTS_QFULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_full_i |-> !cts_i); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_i <= DEPTH_C); // R8
endmodule

bind tcp_tx_packetizer tcp_pktz_chk #(.ADDR_W(ADDR_W), .MTU(MTU), .LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cts_i(cts_o),
  .desc_valid_i(desc_valid_o), .desc_ready_i(desc_ready_i),
  .desc_start_i(desc_start_o), .desc_len_i(desc_len_o),
  .dq_full_i(dq_full), .push_i(seg_push), .pend_len_i(pend_len), .used_i(used_cnt)
);

// File: tb/tcp_tx_packetizer_test.sv
`timescale 1ns/1ps
module tcp_tx_packetizer_test;
  localparam int AW = 6;
  localparam int MT = 16;
  localparam int W  = 10;
  localparam int LW = $clog2(MT + 1);

  logic          clk = 0;
  logic          rst_n = 0;
  logic [7:0]    din = 0;
  logic          vin = 0, snd = 0, desc_ready = 0, rel_valid = 0;
  logic [AW:0]   rel_len = 0;
  logic [AW-1:0] rd_addr = 0;
  logic          cts, desc_valid;
  logic [AW-1:0] desc_start;
  logic [LW-1:0] desc_len;
  logic [7:0]    rd_data;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  tcp_tx_packetizer #(.ADDR_W(AW), .MTU(MT), .WAIT_TICKS(W), .DQ_DEPTH(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .vin_i(vin), .cts_o(cts), .snd_i(snd),
    .desc_valid_o(desc_valid), .desc_ready_i(desc_ready), .desc_start_o(desc_start),
    .desc_len_o(desc_len), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rel_valid_i(rel_valid), .rel_len_i(rel_len)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic burst(input int v0, input int n, input bit force_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vin = 1; din = 8'(v0 + i); snd = force_last && (i == n - 1);
    end
    @(negedge clk); vin = 0; snd = 0;
  endtask

  task automatic pop(input string req, input int es, input int el);
    chk({req, " valid"}, int'(desc_valid), 1);
    chk({req, " start"}, int'(desc_start), es);
    chk({req, " len"}, int'(desc_len), el);
    desc_ready = 1; rel_valid = 1; rel_len = (AW+1)'(el);
    @(negedge clk); desc_ready = 0; rel_valid = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cts", int'(cts), 1);
    chk("R1 desc_valid", int'(desc_valid), 0);
  endtask

  task automatic t_force();
    burst(8'hA0, 4, 1);
    rd_addr = 2;
    @(negedge clk);
    chk("R11 read byte", int'(rd_data), 8'hA2);
    pop("R5", 0, 4);
    chk("R1 first start after force", int'(desc_valid), 0);
  endtask

  task automatic t_force_empty();
    @(negedge clk); snd = 1;
    @(negedge clk); snd = 0;
    repeat (15) @(negedge clk);
    chk("R6 no descriptor", int'(desc_valid), 0);
  endtask

  task automatic t_idle();
    burst(8'h10, 5, 0);
    repeat (W - 1) @(negedge clk);
    chk("R3 not early", int'(desc_valid), 0);
    @(negedge clk);
    pop("R3", 4, 5);
  endtask

  task automatic t_restart();
    burst(8'h20, 1, 0);
    repeat (W - 3) @(negedge clk);
    burst(8'h21, 1, 0);
    repeat (W - 3) @(negedge clk);
    burst(8'h22, 1, 0);
    chk("R4 still open", int'(desc_valid), 0);
    repeat (W - 1) @(negedge clk);
    chk("R4 not early", int'(desc_valid), 0);
    @(negedge clk);
    pop("R4", 9, 3);
  endtask

  task automatic t_size();
    burst(8'h30, MT, 0);
    pop("R2", 12, MT);
  endtask

  task automatic t_order();
    burst(8'h40, 2, 1);
    burst(8'h50, 3, 1);
    burst(8'h60, 1, 1);
    repeat (3) @(negedge clk);
    pop("R10 first", 28, 2);
    pop("R10 second", 30, 3);
    pop("R10 third", 33, 1);
    chk("R10 drained", int'(desc_valid), 0);
  endtask

  task automatic t_qfull();
    for (int k = 0; k < 4; k++) burst(8'h70 + k, 1, 1);
    chk("R9 cts low on full queue", int'(cts), 0);
    for (int k = 0; k < 4; k++) pop("R9 drain", 34 + k, 1);
    chk("R9 cts back", int'(cts), 1);
  endtask

  task automatic t_space();
    int cnt = 0;
    bit last = 0;
    while (!last && cnt < 70) begin
      @(negedge clk);
      chk("R7 cts vs free", int'(cts), (cnt < 62) ? 1 : 0);
      if (!cts) last = 1;
      vin = 1; din = 8'(8'hC0 + cnt);
      cnt++;
    end
    @(negedge clk); vin = 0;
    chk("R8 bytes accepted", cnt, 63);
    rd_addr = 6'd36;
    @(negedge clk);
    chk("R8 extra byte stored", int'(rd_data), 8'hFE);
    snd = 1;
    @(negedge clk); snd = 0;
    pop("R10 wrap a", 38, 16);
    pop("R10 wrap b", 54, 16);
    pop("R10 wrap c", 6, 16);
    pop("R10 wrap d", 22, 15);
    chk("R12 cts after release", int'(cts), 1);
  endtask

  initial begin
    t_reset();
    t_force();
    t_force_empty();
    t_idle();
    t_restart();
    t_size();
    t_order();
    t_qfull();
    t_space();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule